// File: doc/BRIEF.md
# Pixel Matrix Row Readout Sequencer

This block steps through a pixel matrix one row at a time and produces the control pattern used for correlated double sampling. For every row visit it enables that row's gate and waits a settle time. It then raises a first sample strobe, drives the row's clear line, raises a second sample strobe and finally drops the gate for one cycle before advancing. The strobes are shared by all column channels. The row gate and clear lines are one-hot vectors, one bit per row.

Each phase has a length in clock cycles taken from its own input. A frame begins on a start strobe and ends with a one-cycle done pulse. After the pulse the sequencer either waits for the next start or, in continuous mode, begins the next frame at once. In paired mode two adjacent rows are driven together. Pairing halves the number of row visits per frame.

The state machine has seven named states. `ST_IDLE` waits for a start. `ST_SETTLE` covers the gate settling time, `ST_SAMP1` the first sample and `ST_CLEAR` the clear pulse. `ST_SAMP2` covers the second sample and `ST_RELEASE` is the single gate-off cycle. `ST_DONE` is the end-of-frame pulse. The transitions are:
- IDLE→SETTLE on start.
- SETTLE→SAMP1, SAMP1→CLEAR and CLEAR→SAMP2 when the phase timer expires.
- SAMP2→RELEASE when the phase timer expires.
- RELEASE→SETTLE when more rows remain, and RELEASE→DONE after the last row.
- DONE→SETTLE in continuous mode, otherwise DONE→IDLE.

Top module: `pxrow_sequencer`

## Requirements
- R1: After reset, every gate and clear bit is 0. Both strobes and frame_done are 0, and row_idx is 0.
- R2: A frame_start seen high in the idle state enters the settle phase at the next edge. In that phase row 0 has its gate enabled.
- R3: Each row visit runs in a fixed order, with the gate enabled in the first four phases. Settle lasts dur_settle cycles, sample1 lasts dur_samp1 cycles, clear lasts dur_clear cycles and sample2 lasts dur_samp2 cycles. The clear phase drives clear_en on the gated row(s). The visit then ends with exactly one cycle in which every gate is off.
- R4: At most one row has its gate enabled in single mode, and at most two in paired mode. A clear bit is set only on a row whose gate is also set.
- R5: A duration input of 0 gives a phase of 1 cycle.
- R6: pair_mode is captured at each frame start. When it is 1, rows r and r+1 are enabled together, with r even. row_idx shows r and advances by 2 per visit.
- R7: frame_done is high for exactly one cycle. That cycle directly follows the gate-off cycle of the last row visit, and row_idx still shows that last row.
- R8: With continuous=1 at the done cycle, the next cycle is the settle phase of row 0. With continuous=0 the block returns to idle with all outputs low and row_idx 0.
- R9: A frame_start during an active frame has no effect on the sequence.
- R10: sample1 and sample2 are never high together, and neither is high while all gates are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Starts a frame when idle |
| pair_mode | input | 1 | 1 = drive adjacent row pairs |
| continuous | input | 1 | 1 = restart after frame end |
| dur_settle | input | DUR_W | Gate settle length, cycles |
| dur_samp1 | input | DUR_W | First sample length, cycles |
| dur_clear | input | DUR_W | Clear pulse length, cycles |
| dur_samp2 | input | DUR_W | Second sample length, cycles |
| gate_en | output | N_ROWS | One-hot row gate enables |
| clear_en | output | N_ROWS | Row clear enables |
| sample1 | output | 1 | First column sample strobe |
| sample2 | output | 1 | Second column sample strobe |
| row_idx | output | ROW_W | Current row (first of pair) |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that N_ROWS is even whenever paired mode is used, so that a pair never runs off the last row. They also assume that the duration inputs stay constant while a phase is running. The bench writes all durations and mode inputs on the falling edge before a start, and changes them only while the block is idle. The single exception is the continuous flag, which it drops in the middle of a frame, well before the done cycle.

// File: rtl/pxrow_pkg.sv
package pxrow_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMP1,
        ST_CLEAR,
        ST_SAMP2,
        ST_RELEASE,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/pxrow_phase_timer.sv
module pxrow_phase_timer #(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DUR_W-1:0] limit,
    output logic             expired
);
    localparam logic [DUR_W-1:0] ONE  = DUR_W'(1);
    localparam logic [DUR_W-1:0] FULL = '1;

    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] eff_limit;

    // a programmed zero still yields one cycle
    assign eff_limit = (limit == '0) ? ONE : limit;
    assign expired   = (cnt_q >= eff_limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ONE;
        end else if (restart) begin
            cnt_q <= ONE;
        end else if (cnt_q != FULL) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    AST_TIMER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0); // R5
    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == ONE)); // R3
endmodule

// File: rtl/pxrow_line_driver.sv
module pxrow_line_driver #(
    parameter int N_ROWS = 64,
    parameter int ROW_W  = 6
) (
    input  logic [ROW_W-1:0]  row,
    input  logic              pair,
    input  logic              gate_on,
    input  logic              clear_on,
    output logic [N_ROWS-1:0] gate_en,
    output logic [N_ROWS-1:0] clear_en
);
    logic [ROW_W:0] row_ext;
    logic [ROW_W:0] row_hi;

    assign row_ext = {1'b0, row};
    assign row_hi  = row_ext + (ROW_W+1)'(1);

    for (genvar r = 0; r < N_ROWS; r++) begin : g_line
        localparam logic [ROW_W:0] IDX = (ROW_W+1)'(r);
        logic hit;
        assign hit         = (row_ext == IDX) || (pair && (row_hi == IDX));
        assign gate_en[r]  = gate_on && hit;
        assign clear_en[r] = clear_on && hit;
    end
endmodule

// File: rtl/pxrow_sequencer.sv
module pxrow_sequencer
    import pxrow_pkg::*;
#(
    parameter int N_ROWS = 64,
    parameter int DUR_W  = 8,
    localparam int ROW_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pair_mode,
    input  logic              continuous,
    input  logic [DUR_W-1:0]  dur_settle,
    input  logic [DUR_W-1:0]  dur_samp1,
    input  logic [DUR_W-1:0]  dur_clear,
    input  logic [DUR_W-1:0]  dur_samp2,
    output logic [N_ROWS-1:0] gate_en,
    output logic [N_ROWS-1:0] clear_en,
    output logic              sample1,
    output logic              sample2,
    output logic [ROW_W-1:0]  row_idx,
    output logic              frame_done
);
    localparam logic [ROW_W:0] ROW_LIMIT = (ROW_W+1)'(N_ROWS);

    seq_state_t       state_q, state_n;
    logic [ROW_W-1:0] row_q;
    logic             pair_q;
    logic [DUR_W-1:0] tmr_limit;
    logic             tmr_expired;
    logic             tmr_restart;
    logic [ROW_W:0]   row_step;
    logic [ROW_W:0]   row_next_ext;
    logic             last_row;
    logic             gate_on;
    logic             clear_on;

    assign row_step     = pair_q ? (ROW_W+1)'(2) : (ROW_W+1)'(1);
    assign row_next_ext = {1'b0, row_q} + row_step;
    assign last_row     = (row_next_ext >= ROW_LIMIT);

    // duration for the phase currently running
    always_comb begin
        unique case (state_q)
            ST_SETTLE: tmr_limit = dur_settle;
            ST_SAMP1:  tmr_limit = dur_samp1;
            ST_CLEAR:  tmr_limit = dur_clear;
            ST_SAMP2:  tmr_limit = dur_samp2;
            default:   tmr_limit = '0;
        endcase
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (frame_start) state_n = ST_SETTLE;
            ST_SETTLE:  if (tmr_expired) state_n = ST_SAMP1;
            ST_SAMP1:   if (tmr_expired) state_n = ST_CLEAR;
            ST_CLEAR:   if (tmr_expired) state_n = ST_SAMP2;
            ST_SAMP2:   if (tmr_expired) state_n = ST_RELEASE;
            ST_RELEASE: state_n = last_row ? ST_DONE : ST_SETTLE;
            ST_DONE:    state_n = continuous ? ST_SETTLE : ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    assign tmr_restart = (state_n != state_q);

    pxrow_phase_timer #(.DUR_W(DUR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    // state register together with the row position and captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            pair_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            unique case (state_q)
                ST_IDLE: if (frame_start) begin
                    row_q  <= '0;
                    pair_q <= pair_mode;
                end
                ST_RELEASE: if (!last_row) row_q <= row_next_ext[ROW_W-1:0];
                ST_DONE: begin
                    row_q <= '0;
                    if (continuous) pair_q <= pair_mode;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        gate_on    = 1'b0;
        clear_on   = 1'b0;
        sample1    = 1'b0;
        sample2    = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            ST_SETTLE: gate_on = 1'b1;
            ST_SAMP1:  begin gate_on = 1'b1; sample1 = 1'b1; end
            ST_CLEAR:  begin gate_on = 1'b1; clear_on = 1'b1; end
            ST_SAMP2:  begin gate_on = 1'b1; sample2 = 1'b1; end
            ST_DONE:   frame_done = 1'b1;
            default: ;
        endcase
    end

    assign row_idx = row_q;

    pxrow_line_driver #(.N_ROWS(N_ROWS), .ROW_W(ROW_W)) u_lines (
        .row      (row_q),
        .pair     (pair_q),
        .gate_on  (gate_on),
        .clear_on (clear_on),
        .gate_en  (gate_en),
        .clear_en (clear_en)
    );

    AST_GATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_q |-> $onehot0(gate_en)); // R4
    AST_GATE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_en) <= 2); // R4
    AST_CLEAR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_en & ~gate_en) == '0); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample1 && sample2)); // R10
    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (sample1 || sample2) |-> (gate_en != '0)); // R10
    AST_CLEAR_AFTER_S1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clear_en != '0) |-> $past(sample1)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R7
    AST_DONE_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> $past(gate_en == '0)); // R7
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && !last_row) |=>
            ({1'b0, row_idx} == $past(row_next_ext))); // R6
    AST_ACTIVE_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMP1 && !tmr_expired) |=> (state_q == ST_SAMP1)); // R9
endmodule

// File: tb/pxrow_sequencer_bench.sv
module pxrow_sequencer_bench;
    localparam int NR    = 8;
    localparam int DW    = 8;
    localparam int RW    = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          pair_mode = 1'b0;
    logic          continuous = 1'b0;
    logic [DW-1:0] dur_settle = '0, dur_samp1 = '0, dur_clear = '0, dur_samp2 = '0;
    logic [NR-1:0] gate_en, clear_en;
    logic          sample1, sample2, frame_done;
    logic [RW-1:0] row_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pxrow_sequencer #(.N_ROWS(NR), .DUR_W(DW)) u_pxrow_sequencer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pair_mode(pair_mode), .continuous(continuous),
        .dur_settle(dur_settle), .dur_samp1(dur_samp1),
        .dur_clear(dur_clear), .dur_samp2(dur_samp2),
        .gate_en(gate_en), .clear_en(clear_en),
        .sample1(sample1), .sample2(sample2),
        .row_idx(row_idx), .frame_done(frame_done)
    );

    // phase codes: 0 settle, 1 samp1, 2 clear, 3 samp2, 4 gate-off, 5 done, 6 idle
    task automatic expect_cycle(input int row, input bit pair, input int ph, input string tag);
        logic [NR-1:0] g;
        logic [NR-1:0] c;
        logic          s1, s2, d;
        g = '0;
        for (int r = 0; r < NR; r++)
            if (ph <= 3 && (r == row || (pair && r == row + 1))) g[r] = 1'b1;
        c  = (ph == 2) ? g : '0;
        s1 = (ph == 1);
        s2 = (ph == 3);
        d  = (ph == 5);
        checks++;
        if (gate_en !== g || clear_en !== c || sample1 !== s1 || sample2 !== s2 ||
            frame_done !== d || row_idx !== RW'(row)) begin
            errors++;
            $display("FAIL %s row %0d phase %0d: gate=%b clr=%b s1=%b s2=%b done=%b idx=%0d exp gate=%b clr=%b s1=%b s2=%b done=%b idx=%0d",
                     tag, row, ph, gate_en, clear_en, sample1, sample2, frame_done, row_idx,
                     g, c, s1, s2, d, row);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // runs one frame; with do_start it pulses frame_start first
    task automatic run_frame(input int ds, input int d1, input int dc, input int d2,
                             input bit pair, input bit cont, input bit do_start,
                             input bit inject, input string tag);
        int len[4];
        len[0] = eff(ds); len[1] = eff(d1); len[2] = eff(dc); len[3] = eff(d2);
        if (do_start) begin
            dur_settle = DW'(ds); dur_samp1 = DW'(d1);
            dur_clear = DW'(dc); dur_samp2 = DW'(d2);
            pair_mode = pair;
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        continuous = cont;
        for (int row = 0; row < NR; row += (pair ? 2 : 1)) begin
            for (int ph = 0; ph < 4; ph++) begin
                for (int k = 0; k < len[ph]; k++) begin
                    expect_cycle(row, pair, ph, tag);
                    frame_start = inject && row == 1 && ph == 1 && k == 0;
                    @(negedge clk);
                    frame_start = 1'b0;
                end
            end
            expect_cycle(row, pair, 4, tag);
            @(negedge clk);
        end
        expect_cycle(pair ? NR - 2 : NR - 1, pair, 5, {tag, " R7"});
        @(negedge clk);
        if (!cont) expect_cycle(0, 1'b0, 6, {tag, " R8 idle"});
    endtask

    task automatic t_reset();
        expect_cycle(0, 1'b0, 6, "R1 reset");
        @(negedge clk);
        expect_cycle(0, 1'b0, 6, "R1 idle hold");
    endtask

    task automatic t_single();
        run_frame(2, 3, 1, 2, 1'b0, 1'b0, 1'b1, 1'b0, "R2 R3 R4 R10 single");
    endtask

    task automatic t_zero();
        run_frame(0, 0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 zero durations");
    endtask

    task automatic t_pair();
        run_frame(1, 2, 2, 1, 1'b1, 1'b0, 1'b1, 1'b0, "R6 paired");
        // mode must be recaptured: next frame in single mode
        run_frame(1, 1, 1, 1, 1'b0, 1'b0, 1'b1, 1'b0, "R6 back to single");
    endtask

    task automatic t_ignore();
        run_frame(2, 2, 2, 2, 1'b0, 1'b0, 1'b1, 1'b1, "R9 start ignored");
    endtask

    task automatic t_continuous();
        run_frame(1, 2, 1, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R8 continuous");
        run_frame(1, 2, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 restarted frame");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_zero();
        t_pair();
        t_ignore();
        t_continuous();
        repeat (2) @(negedge clk);
        expect_cycle(0, 1'b0, 6, "R8 stays idle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule